// File: doc/BRIEF.md
# Two-Slot Elastic Pipeline Buffer

This block sits between two stages of a latency-insensitive synchronous pipeline. Items move downstream on a data bus that carries a valid flag. An active-high stop flag moves upstream to signal backpressure. An item is handed over on a channel only in a cycle where valid is high and stop is low. Every register in the block loads on the same rising clock edge. The handshake only decides which registers take a new value.

In its default form the buffer has two storage slots, a primary slot and a spare slot. The primary slot drives the downstream outputs. The spare slot catches the one item that arrives in the same cycle as downstream backpressure, so no item is lost. The upstream stop comes directly from the spare slot's valid flip-flop. A long chain of these buffers therefore has no combinational path along its stop signals.

A parameter set to zero gives the second form. It stores nothing and ties the forward and backward signals straight through, so it adds the handshake to a path without adding latency.

Top module: `elastic_buf`

## Requirements
- R1: While reset is high and in the first cycle after it, valid_out and stop_out are both low.
- R2: When the buffer is empty and valid_in is high, the item is accepted, and on the next clock edge valid_out goes high with data_out equal to that item.
- R3: stop_out is high exactly when the buffer holds two items. It rises only after an edge where an item was accepted while the primary slot was full and stop_in was high. It falls on the edge after any cycle where it was high and stop_in was low.
- R4: While valid_out and stop_in are both high, valid_out and data_out stay unchanged on the next edge.
- R5: Under any pattern of valid_in and stop_in, the items leave in the order they were accepted, with none lost and none duplicated.
- R6: In a cycle where stop_out is high, valid_in and data_in are ignored. No item presented in such a cycle ever appears at the output.
- R7: With stop_in held low and valid_in held high, one item passes per cycle, each one cycle after it was accepted.
- R8: With CAPACITY = 0, valid_out equals valid_in, data_out equals data_in and stop_out equals stop_in in the same cycle.
- R9: The buffer never holds more than two items.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register loads on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | DW | Upstream item |
| valid_in | input | 1 | Upstream item is present |
| stop_out | output | 1 | Backpressure to upstream; upstream holds while high |
| data_out | output | DW | Downstream item |
| valid_out | output | 1 | Downstream item is present |
| stop_in | input | 1 | Backpressure from downstream |

## Verification
The bench steps through every pairing of a 4-cycle repeating valid pattern with a 4-cycle repeating stop pattern. A long pseudo-random phase follows. Across these runs the buffer meets empty, half-full and full states with stop rising and falling in every slot position. A reference occupancy count and an item queue catch loss, duplication, reordering and a mistimed stop_out. Directed runs separate the fill latency and full-rate streaming from the case where a stalled full buffer must drop what upstream offers. A second instance with zero capacity, fed the same stimulus, is compared combinationally every cycle.

// File: rtl/eb_pkg.sv
package eb_pkg;

    // Source selected for the primary slot on the next edge
    typedef enum logic [1:0] {
        MAIN_KEEP     = 2'd0,
        MAIN_FROM_IN  = 2'd1,
        MAIN_FROM_AUX = 2'd2
    } main_sel_e;

    // A channel hands over an item when it is valid and not stopped
    function automatic logic eb_fire(input logic vld, input logic stp);
        return vld & ~stp;
    endfunction

endpackage

// File: rtl/eb_slot.sv
module eb_slot #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          v_d,
    input  logic [DW-1:0] d_d,
    output logic          v_q,
    output logic [DW-1:0] d_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            d_q <= '0;
        end else if (load) begin
            v_q <= v_d;
            d_q <= d_d;
        end
    end

endmodule

// File: rtl/eb_skid_ctrl.sv
module eb_skid_ctrl
    import eb_pkg::*;
(
    input  logic      valid_in,
    input  logic      stop_in,
    input  logic      main_v,
    input  logic      aux_v,
    output main_sel_e main_sel,
    output logic      main_load,
    output logic      main_v_d,
    output logic      aux_load,
    output logic      aux_v_d
);

    logic main_free;
    logic aux_store;

    always_comb begin
        // Primary slot can take a new value if it is empty or draining now
        main_free = ~main_v | ~stop_in;
        // Spare slot catches an input that arrives while the primary is stuck
        aux_store = ~main_free & eb_fire(valid_in, aux_v);

        main_load = main_free;
        main_v_d  = aux_v | valid_in;
        if (!main_free)
            main_sel = MAIN_KEEP;
        else if (aux_v)
            main_sel = MAIN_FROM_AUX;
        else
            main_sel = MAIN_FROM_IN;

        // Spare empties whenever the primary moves on
        aux_load = main_free | aux_store;
        aux_v_d  = aux_store;
    end

endmodule

// File: rtl/elastic_buf.sv
module elastic_buf
    import eb_pkg::*;
#(
    parameter int DW       = 8,
    parameter int CAPACITY = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] data_in,
    input  logic          valid_in,
    output logic          stop_out,
    output logic [DW-1:0] data_out,
    output logic          valid_out,
    input  logic          stop_in
);

    localparam bit HAS_STORAGE = (CAPACITY != 0);

    generate
        if (!HAS_STORAGE) begin : g_pass
            assign data_out  = data_in;
            assign valid_out = valid_in;
            assign stop_out  = stop_in;
        end else begin : g_skid
            main_sel_e     main_sel;
            logic          main_load, main_v_d, aux_load, aux_v_d;
            logic          main_v, aux_v;
            logic [DW-1:0] main_d, aux_d, main_d_next;

            eb_skid_ctrl u_ctrl (
                .valid_in  (valid_in),
                .stop_in   (stop_in),
                .main_v    (main_v),
                .aux_v     (aux_v),
                .main_sel  (main_sel),
                .main_load (main_load),
                .main_v_d  (main_v_d),
                .aux_load  (aux_load),
                .aux_v_d   (aux_v_d)
            );

            always_comb begin
                case (main_sel)
                    MAIN_FROM_AUX: main_d_next = aux_d;
                    MAIN_FROM_IN:  main_d_next = data_in;
                    default:       main_d_next = main_d;
                endcase
            end

            eb_slot #(.DW(DW)) u_main (
                .clk  (clk),
                .rst  (rst),
                .load (main_load),
                .v_d  (main_v_d),
                .d_d  (main_d_next),
                .v_q  (main_v),
                .d_q  (main_d)
            );

            eb_slot #(.DW(DW)) u_aux (
                .clk  (clk),
                .rst  (rst),
                .load (aux_load),
                .v_d  (aux_v_d),
                .d_d  (data_in),
                .v_q  (aux_v),
                .d_q  (aux_d)
            );

            assign data_out  = main_d;
            assign valid_out = main_v;
            assign stop_out  = aux_v;

            AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (!valid_out && !stop_out)); // R1
            AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (rst)
                (valid_in && !stop_out && !valid_out) |=> (valid_out && data_out == $past(data_in))); // R2
            AST_STOP_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
                $rose(stop_out) |-> $past(valid_in && valid_out && stop_in)); // R3
            AST_STOP_DROP: assert property (@(posedge clk) disable iff (rst)
                (stop_out && !stop_in) |=> !stop_out); // R3
            AST_HOLD_UNDER_STOP: assert property (@(posedge clk) disable iff (rst)
                (valid_out && stop_in) |=> (valid_out && $stable(data_out))); // R4
        end
    endgenerate

endmodule

// File: tb/elastic_buf_test.sv
`timescale 1ns/1ps
module elastic_buf_test;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] data_in;
    logic          valid_in;
    logic          stop_in;
    logic          stop_out, valid_out;
    logic [DW-1:0] data_out;
    logic          stop_out_z, valid_out_z;
    logic [DW-1:0] data_out_z;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    elastic_buf #(.DW(DW), .CAPACITY(2)) uut (
        .clk(clk), .rst(rst), .data_in(data_in), .valid_in(valid_in),
        .stop_out(stop_out), .data_out(data_out), .valid_out(valid_out),
        .stop_in(stop_in)
    );

    elastic_buf #(.DW(DW), .CAPACITY(0)) uut_zero (
        .clk(clk), .rst(rst), .data_in(data_in), .valid_in(valid_in),
        .stop_out(stop_out_z), .data_out(data_out_z), .valid_out(valid_out_z),
        .stop_in(stop_in)
    );

    // reference model state
    logic [DW-1:0] sb[$];
    int            occ;
    logic          last_in_fire;
    logic          prev_stall;
    logic [DW-1:0] prev_data;
    logic [DW-1:0] next_item;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge and check the settled outputs
    task automatic step(input logic vin, input logic [DW-1:0] din, input logic sin);
        logic in_fire, out_fire;
        @(negedge clk);
        valid_in = vin;
        data_in  = din;
        stop_in  = sin;
        #1;
        // R8: zero-capacity variant is a straight wire
        check(valid_out_z == vin, "R8 valid", int'(valid_out_z), int'(vin));
        check(data_out_z == din,  "R8 data",  int'(data_out_z),  int'(din));
        check(stop_out_z == sin,  "R8 stop",  int'(stop_out_z),  int'(sin));
        // R3/R9: stop_out mirrors a full buffer, occupancy bounded
        check(stop_out == (occ == 2), "R3 stop_out vs occupancy", int'(stop_out), int'(occ == 2));
        check(occ <= 2, "R9 occupancy", occ, 2);
        check(valid_out == (occ != 0), "R5 valid_out vs occupancy", int'(valid_out), int'(occ != 0));
        if (prev_stall)
            check(valid_out && data_out == prev_data, "R4 hold under stop", int'(data_out), int'(prev_data));
        in_fire  = vin & ~stop_out;
        out_fire = valid_out & ~sin;
        if (out_fire) begin
            if (sb.size() == 0)
                check(1'b0, "R5 unexpected item", int'(data_out), -1);
            else begin
                check(data_out == sb[0], "R5 order", int'(data_out), int'(sb[0]));
                void'(sb.pop_front());
            end
        end
        if (in_fire) sb.push_back(din);
        occ          = occ + int'(in_fire) - int'(out_fire);
        last_in_fire = in_fire;
        prev_stall   = valid_out & sin;
        prev_data    = data_out;
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b0);
        check(occ == 0 && sb.size() == 0, "R5 drained", occ, 0);
    endtask

    // Source that obeys the hold rule, valid pattern vp, stop pattern sp
    task automatic run_pattern(input logic [3:0] vp, input logic [3:0] sp, input int cycles);
        logic hold;
        hold = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            logic v;
            v = hold ? 1'b1 : vp[c % 4];
            step(v, next_item, sp[c % 4]);
            if (last_in_fire) next_item = next_item + 8'd1;
            hold = v & ~last_in_fire;
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; valid_in = 1'b0; data_in = '0; stop_in = 1'b0;
        occ = 0; last_in_fire = 1'b0; prev_stall = 1'b0; prev_data = '0; next_item = 8'd1;
        repeat (3) @(negedge clk);
        #1;
        check(!valid_out && !stop_out, "R1 during reset", int'({valid_out, stop_out}), 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!valid_out && !stop_out, "R1 after reset", int'({valid_out, stop_out}), 0);

        // R2: fill latency from empty
        step(1'b1, 8'h5A, 1'b0);
        step(1'b0, 8'h00, 1'b1);
        check(valid_out && data_out == 8'h5A, "R2 fill", int'(data_out), 8'h5A);
        drain();

        // R7: full-rate streaming
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 8'(8'h20 + i), 1'b0);
            if (i > 0)
                check(valid_out && data_out == 8'(8'h20 + i - 1), "R7 stream", int'(data_out), 8'h20 + i - 1);
        end
        drain();

        // R6: offers made while full are dropped
        step(1'b1, 8'hA1, 1'b1);
        step(1'b1, 8'hA2, 1'b1);
        check(stop_out == 1'b0, "R3 stop before full", int'(stop_out), 0);
        step(1'b1, 8'hEE, 1'b1);
        check(stop_out == 1'b1, "R3 stop when full", int'(stop_out), 1);
        step(1'b1, 8'hEF, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        step(1'b0, 8'h00, 1'b0);
        check(valid_out && data_out == 8'hA1, "R6 first kept", int'(data_out), 8'hA1);
        step(1'b0, 8'h00, 1'b0);
        check(valid_out && data_out == 8'hA2, "R6 second kept", int'(data_out), 8'hA2);
        check(stop_out == 1'b0, "R3 stop dropped", int'(stop_out), 0);
        step(1'b0, 8'h00, 1'b0);
        check(!valid_out, "R6 nothing extra", int'(valid_out), 0);
        drain();

        // R5: sweep every pair of 4-cycle valid and stop patterns
        for (int vp = 0; vp < 16; vp++)
            for (int sp = 0; sp < 16; sp++) begin
                run_pattern(4'(vp), 4'(sp), 24);
                drain();
            end

        // R5: pseudo-random phase
        lfsr = 16'hACE1;
        begin
            logic hold;
            hold = 1'b0;
            for (int c = 0; c < 3000; c++) begin
                logic v;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                v = hold ? 1'b1 : lfsr[0];
                step(v, next_item, lfsr[3] & lfsr[5]);
                if (last_in_fire) next_item = next_item + 8'd1;
                hold = v & ~last_in_fire;
            end
        end
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(64'd200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule